// File: doc/BRIEF.md
# Context-Modeled Bitwise Instruction Decoder

This block rebuilds a fixed-width instruction word from a compressed serial bit stream. It uses a binary arithmetic decoder that draws on a table of per-position probabilities. Each table entry holds two probability bytes and a context pointer. A byte gives the chance, out of 256, that its bit is zero. When context mode is on, an entry's second byte takes over whenever the bit named by its pointer has already decoded as one.

Every word is coded on its own. The decoder state is cleared at each word boundary, so a word can be decoded starting from any word boundary, for example at a branch target. Positions are decoded from the most significant bit down. A position whose probability byte is at either extreme is produced without reading the stream. This is how constant fields cost no compressed bits. Because the compressed words have variable length, a four-state machine takes stream bits only when the arithmetic state needs them, and finds the word boundaries itself.

The states are as follows:
- `ST_LOAD` fills the code register from the stream. When the last load bit is taken (LOAD→BIT), the range is set to all ones and decoding starts at the top position.
- `ST_BIT` decodes one position. It moves to BIT→NORM when the range falls below half scale. Otherwise it steps to the next lower position (BIT→BIT), or goes to BIT→EMIT after position 0.
- `ST_NORM` shifts one stream bit in per accepted handshake. Once the range is back at half scale or above, it leaves by NORM→BIT or NORM→EMIT.
- `ST_EMIT` presents the word for one cycle and then returns by EMIT→LOAD.

Top module: `ctxdec_top`

## Requirements
- R1: After reset, `ins_valid` is 0 and `s_ready` is 1: the block waits to load a word.
- R2: Each word starts by taking exactly 16 stream bits, first bit most significant, into a 16-bit code register, with the 16-bit range set to 0xFFFF.
- R3: Positions are decoded from IW-1 down to 0. With probability byte p (1..254), the split is r0 = floor(range*p/256). If code < r0, the bit is 0 and range becomes r0. Otherwise the bit is 1, r0 is subtracted from both code and range.
- R4: After a split, while range bit 15 is 0, the block takes one stream bit per shift: range doubles and the bit enters the code LSB. `s_ready` is 1 only in the load and shift states, and a cycle without `s_valid` leaves the state unchanged.
- R5: A probability byte of 255 yields bit 0 and a byte of 0 yields bit 1. Neither consumes a stream bit nor changes range or code.
- R6: With `ctx_en` = 0, every position uses its first probability byte (`mdl_p0`), whatever its context pointer.
- R7: With `ctx_en` = 1 and a valid pointer, a position uses `mdl_p1` when the word bit at the pointer is 1, and `mdl_p0` when it is 0.
- R8: A pointer is valid only if it is greater than the current position and at most IW-1. Any other pointer falls back to `mdl_p0`, even in context mode.
- R9: When position 0 is done, `ins_valid` is high for exactly one cycle with the full word, and `s_ready` is 0 in that cycle. The next word then begins with a fresh load. A word consumes exactly 16 plus its shift count in stream bits.
- R10: A cycle with `mdl_we` high writes `mdl_p0`, `mdl_p1` and `mdl_ctx` into the table entry at `mdl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_en | input | 1 | 1 selects context-modeled probabilities |
| mdl_we | input | 1 | Table write strobe |
| mdl_addr | input | $clog2(IW) | Table entry (bit position) to write |
| mdl_p0 | input | 8 | Probability of zero (base, or context bit 0) |
| mdl_p1 | input | 8 | Probability of zero when context bit is 1 |
| mdl_ctx | input | $clog2(IW) | Context bit position for this entry |
| s_valid | input | 1 | Stream bit present |
| s_bit | input | 1 | Compressed stream bit |
| s_ready | output | 1 | Block takes a stream bit this cycle |
| ins_valid | output | 1 | Decoded word present (one-cycle pulse) |
| ins_word | output | IW | Decoded instruction word |

## Verification
On every cycle, the assertions check that the range is normalised whenever a split happens and is below half scale whenever a shift is requested. They also check that the code value stays below the range, that the load ends with a full range, that a stalled shift holds its state, and that the output pulse lasts one cycle with no stream request during it. Whether the decoded bits are the right ones can be shown only by the bench's scenarios. These scenarios encode words arithmetically and compare the results. They cover all 256 words of an 8-bit configuration, with and without context, plus forced-bit copy chains and invalid pointers. The same scenarios show the exact number of stream bits each word consumes, which fixes the word boundaries.

// File: rtl/ctxdec_pkg.sv
package ctxdec_pkg;
    localparam int RNG_W  = 16;
    localparam int PROB_W = 8;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_BIT,
        ST_NORM,
        ST_EMIT
    } dec_state_t;
endpackage

// File: rtl/ctxdec_model.sv
module ctxdec_model
    import ctxdec_pkg::*;
#(
    parameter int IW = 88,
    localparam int XW = $clog2(IW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [XW-1:0]     waddr,
    input  logic [PROB_W-1:0] wp0,
    input  logic [PROB_W-1:0] wp1,
    input  logic [XW-1:0]     wctx,
    input  logic [XW-1:0]     rd_pos,
    input  logic [IW-1:0]     word,
    input  logic              ctx_en,
    output logic [PROB_W-1:0] prob
);
    localparam logic [XW-1:0]     LAST_POS = XW'(IW - 1);
    localparam logic [PROB_W-1:0] HALF     = PROB_W'(1) << (PROB_W - 1);

    logic [PROB_W-1:0] p0_q [IW];
    logic [PROB_W-1:0] p1_q [IW];
    logic [XW-1:0]     cx_q [IW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < IW; i++) begin
                p0_q[i] <= HALF;
                p1_q[i] <= HALF;
                cx_q[i] <= '0;
            end
        end else if (we && waddr <= LAST_POS) begin
            p0_q[waddr] <= wp0;
            p1_q[waddr] <= wp1;
            cx_q[waddr] <= wctx;
        end
    end

    logic [XW-1:0] idx;
    logic          idx_ok;

    always_comb begin
        idx    = cx_q[rd_pos];
        idx_ok = ctx_en && (idx > rd_pos) && (idx <= LAST_POS);
        if (idx_ok && word[idx])
            prob = p1_q[rd_pos];
        else
            prob = p0_q[rd_pos];
    end
endmodule

// File: rtl/ctxdec_split.sv
module ctxdec_split
    import ctxdec_pkg::*;
(
    input  logic [RNG_W-1:0]  rng,
    input  logic [RNG_W-1:0]  val,
    input  logic [PROB_W-1:0] prob,
    output logic              bit_o,
    output logic [RNG_W-1:0]  rng_o,
    output logic [RNG_W-1:0]  val_o
);
    localparam int PW = RNG_W + PROB_W;

    logic [PW-1:0]    prod;
    logic [RNG_W-1:0] r0;

    always_comb begin
        prod  = {{PROB_W{1'b0}}, rng} * {{RNG_W{1'b0}}, prob};
        r0    = RNG_W'(prod >> PROB_W);
        bit_o = 1'b0;
        rng_o = rng;
        val_o = val;
        if (prob == '1) begin
            bit_o = 1'b0;
        end else if (prob == '0) begin
            bit_o = 1'b1;
        end else if (val < r0) begin
            bit_o = 1'b0;
            rng_o = r0;
        end else begin
            bit_o = 1'b1;
            rng_o = rng - r0;
            val_o = val - r0;
        end
    end
endmodule

// File: rtl/ctxdec_top.sv
module ctxdec_top
    import ctxdec_pkg::*;
#(
    parameter int IW = 88,
    localparam int XW = $clog2(IW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_en,
    input  logic              mdl_we,
    input  logic [XW-1:0]     mdl_addr,
    input  logic [PROB_W-1:0] mdl_p0,
    input  logic [PROB_W-1:0] mdl_p1,
    input  logic [XW-1:0]     mdl_ctx,
    input  logic              s_valid,
    input  logic              s_bit,
    output logic              s_ready,
    output logic              ins_valid,
    output logic [IW-1:0]     ins_word
);
    localparam int            CW        = $clog2(RNG_W);
    localparam logic [CW-1:0] LOAD_LAST = CW'(RNG_W - 1);
    localparam logic [XW-1:0] TOP_POS   = XW'(IW - 1);

    dec_state_t        state_q, state_n;
    logic [RNG_W-1:0]  rng_q, rng_n, val_q, val_n;
    logic [XW-1:0]     pos_q, pos_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [IW-1:0]     word_q, word_n;

    logic [PROB_W-1:0] prob;
    logic              sp_bit;
    logic [RNG_W-1:0]  sp_rng, sp_val;

    ctxdec_model #(.IW(IW)) u_model (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mdl_we),
        .waddr  (mdl_addr),
        .wp0    (mdl_p0),
        .wp1    (mdl_p1),
        .wctx   (mdl_ctx),
        .rd_pos (pos_q),
        .word   (word_q),
        .ctx_en (ctx_en),
        .prob   (prob)
    );

    ctxdec_split u_split (
        .rng   (rng_q),
        .val   (val_q),
        .prob  (prob),
        .bit_o (sp_bit),
        .rng_o (sp_rng),
        .val_o (sp_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            rng_q   <= '1;
            val_q   <= '0;
            pos_q   <= TOP_POS;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_n;
            rng_q   <= rng_n;
            val_q   <= val_n;
            pos_q   <= pos_n;
            cnt_q   <= cnt_n;
            word_q  <= word_n;
        end
    end

    always_comb begin
        state_n = state_q;
        rng_n   = rng_q;
        val_n   = val_q;
        pos_n   = pos_q;
        cnt_n   = cnt_q;
        word_n  = word_q;
        unique case (state_q)
            ST_LOAD: begin
                if (s_valid) begin
                    val_n = {val_q[RNG_W-2:0], s_bit};
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == LOAD_LAST) begin
                        rng_n   = '1;
                        pos_n   = TOP_POS;
                        cnt_n   = '0;
                        state_n = ST_BIT;
                    end
                end
            end
            ST_BIT: begin
                rng_n         = sp_rng;
                val_n         = sp_val;
                word_n[pos_q] = sp_bit;
                if (!sp_rng[RNG_W-1])
                    state_n = ST_NORM;
                else if (pos_q == '0)
                    state_n = ST_EMIT;
                else
                    pos_n = pos_q - 1'b1;
            end
            ST_NORM: begin
                if (s_valid) begin
                    rng_n = {rng_q[RNG_W-2:0], 1'b0};
                    val_n = {val_q[RNG_W-2:0], s_bit};
                    if (rng_q[RNG_W-2]) begin
                        if (pos_q == '0) begin
                            state_n = ST_EMIT;
                        end else begin
                            pos_n   = pos_q - 1'b1;
                            state_n = ST_BIT;
                        end
                    end
                end
            end
            ST_EMIT: begin
                state_n = ST_LOAD;
            end
            default: state_n = ST_LOAD;
        endcase
    end

    always_comb begin
        s_ready   = (state_q == ST_LOAD) || (state_q == ST_NORM);
        ins_valid = (state_q == ST_EMIT);
        ins_word  = word_q;
    end
endmodule

// File: rtl/ctxdec_chk.sv
module ctxdec_chk
    import ctxdec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             s_ready,
    input logic             ins_valid,
    input dec_state_t       state,
    input logic [RNG_W-1:0] rng,
    input logic [RNG_W-1:0] val
);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> !ins_valid);

    // R9
    emit_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !s_ready);

    // R4
    shift_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM) |-> !rng[RNG_W-1]);

    // R3
    split_normed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT) |-> rng[RNG_W-1]);

    // R3
    code_below_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT || state == ST_NORM) |-> (val < rng));

    // R2
    load_full_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && s_valid) |=> (state == ST_LOAD || rng == '1));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM && !s_valid) |=> ($stable(rng) && $stable(val)));
endmodule

bind ctxdec_top ctxdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .ins_valid (ins_valid),
    .state     (state_q),
    .rng       (rng_q),
    .val       (val_q)
);

// File: tb/sim_ctxdec_top.sv
module sim_ctxdec_top;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 8;
    localparam int XW = $clog2(IW);

    logic clk = 0, rst_n = 0, ctx_en = 0, mdl_we = 0;
    logic [XW-1:0] mdl_addr = '0, mdl_ctx = '0;
    logic [7:0] mdl_p0 = '0, mdl_p1 = '0;
    logic s_valid = 0, s_bit = 0, s_ready, ins_valid;
    logic [IW-1:0] ins_word;

    int n_chk = 0, n_fail = 0, tick = 0;
    int pa [IW], pb [IW], ci [IW];
    bit ebuf [0:1023];
    int elen;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxdec_top #(.IW(IW)) u0 (.*);

    function automatic int probof(int pos, logic [IW-1:0] w, bit ce);
        int idx = ci[pos];
        if (ce && idx > pos && idx < IW) return w[idx] ? pb[pos] : pa[pos];
        return pa[pos];
    endfunction

    task automatic encode(input logic [IW-1:0] w, input bit ce);
        int lo = 0, rg = 65535, p, r0, j;
        elen = 0;
        for (int pos = IW - 1; pos >= 0; pos--) begin
            p = probof(pos, w, ce);
            if (p == 255 || p == 0) continue;
            r0 = (rg * p) >> 8;
            if (!w[pos]) rg = r0;
            else begin
                lo += r0; rg -= r0;
                if (lo >= 65536) begin
                    lo -= 65536;
                    j = elen - 1;
                    while (ebuf[j]) begin ebuf[j] = 0; j--; end
                    ebuf[j] = 1;
                end
            end
            while (rg < 32768) begin
                ebuf[elen] = lo[15]; elen++;
                lo = (lo << 1) & 65535; rg = rg << 1;
            end
        end
        for (int k = 15; k >= 0; k--) begin ebuf[elen] = lo[k]; elen++; end
    endtask

    task automatic load_model;
        for (int p = 0; p < IW; p++) begin
            @(negedge clk);
            mdl_we = 1; mdl_addr = XW'(p);
            mdl_p0 = 8'(pa[p]); mdl_p1 = 8'(pb[p]); mdl_ctx = XW'(ci[p]);
        end
        @(negedge clk);
        mdl_we = 0;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_word(input logic [IW-1:0] w, input bit ce, input string tag);
        int rd = 0, cyc = 0;
        bit pend = 0, got = 0;
        ctx_en = ce;
        encode(w, ce);
        while (!got && cyc < 3000) begin
            @(negedge clk);
            cyc++; tick++;
            if (pend) rd++;
            if (ins_valid) begin
                got = 1;
                check(ins_word == w, {tag, " word"}, int'(ins_word), int'(w));
                check(rd == elen, {tag, " R9 R2 R4 bits used"}, rd, elen);
            end else begin
                s_valid = (tick % 5 != 3) && (rd < elen);
                s_bit   = (rd < elen) ? ebuf[rd] : 1'b0;
                pend    = s_valid && s_ready;
            end
        end
        s_valid = 0;
        if (!got) check(0, {tag, " R9 no word"}, rd, elen);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", n_chk, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ins_valid == 0 && s_ready == 1, "R1 reset", {ins_valid, s_ready}, 1);
        rst_n = 1;

        // R10 R3 R6: order-0 model, full sweep
        for (int p = 0; p < IW; p++) begin
            pa[p] = 1 + ((p * 73 + 29) % 254); pb[p] = 3; ci[p] = (p + 1) % IW;
        end
        load_model();
        for (int w = 0; w < 256; w++) run_word(8'(w), 0, "R3 R6 sweep");

        // R7 R8: context model, top and pos 3 pointers invalid
        for (int p = 0; p < IW; p++) begin
            pa[p] = 1 + ((p * 41 + 7) % 254);
            pb[p] = 1 + ((p * 97 + 200) % 254);
            ci[p] = (p < IW - 1) ? p + 1 : 0;
        end
        ci[3] = 2;
        load_model();
        for (int w = 0; w < 256; w++) run_word(8'(w), 1, "R7 R8 sweep");

        // R5 R6 R7: forced copy chain, no arithmetic bits
        for (int p = 0; p < IW; p++) begin
            pa[p] = 255; pb[p] = 0; ci[p] = p + 1;
        end
        pa[IW-1] = 0; ci[IW-1] = 0;
        load_model();
        run_word(8'h80, 0, "R5 R6 forced order0");
        run_word(8'hFF, 1, "R5 R7 forced copy");

        // R5 R7: free top bit copied down
        pa[IW-1] = 90;
        load_model();
        run_word(8'h00, 1, "R5 R7 copy zero");
        run_word(8'hFF, 1, "R5 R7 copy one");

        // R8: pointers at or below own position fall back
        for (int p = 0; p < IW; p++) begin
            pa[p] = 255; pb[p] = 0; ci[p] = 0;
        end
        ci[5] = 5;
        load_model();
        run_word(8'h00, 1, "R8 invalid pointer");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule